// File: doc/BRIEF.md
# Masked pseudo-random test vector generator

This block produces the stimulus words for a built-in self test of a logic block with a wide input word. A free-running Galois LFSR supplies one pseudo-random word per emitted vector. A small table of partial masks sits beside it. Each entry holds a per-position care enable and a per-position forced value. On the vectors that a sequencer selects, the masked positions are overwritten with their forced values and every free position keeps the LFSR bit. One test session emits a configured total count of vectors, some raw and some masked. After that count the generator raises done and freezes.

Two arrangements are supported. In interleaved mode every third vector is masked, and the mask index steps around the loaded masks. In block mode mask 0 is held for a programmable run of vectors, then mask 1, and so on up to the last loaded mask. After that the session continues with raw pseudo-random words. In block mode an optional hold setting keeps the pseudo-random part unchanged across each mask change, so only the masked positions toggle on that vector. The mask table can be written at any time through its own write port, for example by a tester or a processor.

Top module: `masked_tpg`

## Requirements
- R1: After reset `vec_valid`, `vec_masked` and `done` are 0 and `mask_idx` is 0.
- R2: The raw word follows s' = (s >> 1) ^ (s[0] ? 32'h8020_0003 : 0) (default width 32). Vector 0 of a session equals the seed. Each later vector is s' of the previous one, except for the held vectors of R6.
- R3: A masked vector equals (lfsr & ~care) | (value & care). Here care and value are the table entry named by `mask_idx`.
- R4: In interleaved mode (`cfg_mode`=0) with `cfg_nmask`≠0, vector k is masked exactly when k mod 3 = 2, and its index is (k div 3) mod `cfg_nmask`.
- R5: In block mode (`cfg_mode`=1) vector k is masked exactly when `cfg_run`≠0 and k < `cfg_nmask`·`cfg_run`, and its index is k div `cfg_run`. All later vectors are raw.
- R6: In block mode with `cfg_hold`=1, each vector k > 0 with k mod `cfg_run` = 0 and k ≤ `cfg_nmask`·`cfg_run` reuses the LFSR word of vector k−1.
- R7: `vec_valid` is high on exactly `cfg_total` consecutive cycles, starting the cycle after an accepted start. `done` rises the cycle after the last vector and stays high until the next accepted start. While idle, `vec_out` does not change.
- R8: The mode, hold, mask-count, run, total and seed inputs are captured when a start is accepted. Changes made to them during a session have no effect on it.
- R9: A zero seed is replaced by 1, and the LFSR never holds the value 0.
- R10: A mask table write takes effect for every masked vector emitted after the write.
- R11: A start with `cfg_total`=0 emits no vector and raises `done` on the next cycle.
- R12: A start pulse during a busy session is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a session (accepted only when idle) |
| cfg_mode | input | 1 | 0 interleaved, 1 block arrangement |
| cfg_hold | input | 1 | Block mode: keep the LFSR word across mask changes |
| cfg_nmask | input | IW+1 (5) | Number of masks used in the session |
| cfg_run | input | RW (8) | Block mode: vectors per mask |
| cfg_total | input | CW (16) | Total vectors in the session |
| cfg_seed | input | W (32) | LFSR seed |
| mw_en | input | 1 | Mask table write strobe |
| mw_addr | input | IW (4) | Mask table entry to write |
| mw_care | input | W (32) | Care enables for the entry |
| mw_value | input | W (32) | Forced values for the entry |
| vec_out | output | W (32) | Test vector |
| vec_valid | output | 1 | Vector on `vec_out` belongs to the session |
| vec_masked | output | 1 | Current vector is masked |
| mask_idx | output | IW (4) | Index of the applied mask (0 when raw) |
| done | output | 1 | Session finished |

## Verification
A wrong LFSR step or a missed hold shows up at once as a word mismatch on the next vector. From then on every later word is wrong, so a single bad advance is visible for the rest of the session. A slip in the phase, run or mask counter first shows as a wrong `vec_masked` or `mask_idx` at the next mask boundary, at most three vectors away in interleaved mode and one run away in block mode. A wrong vector counter shows as `done` one or more cycles early or late against the configured total.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
   typedef enum logic {
      ARR_INTERLEAVE = 1'b0,
      ARR_BLOCK      = 1'b1
   } arr_mode_e;

   // interleaved arrangement: one masked word after this many raw ones
   localparam int unsigned RAW_PER_MASKED = 2;
   localparam int unsigned ILV_PERIOD     = RAW_PER_MASKED + 1;
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
   parameter int unsigned W    = 32,
   parameter logic [W-1:0] TAPS = 32'h8020_0003
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         adv,
   output logic [W-1:0] state
);
   logic [W-1:0] nxt;

   // right-shifting Galois form, one XOR per tapped bit
   for (genvar b = 0; b < W; b++) begin : g_bit
      if (b == W - 1) begin : g_top
         assign nxt[b] = TAPS[b] & state[0];
      end else begin : g_mid
         assign nxt[b] = state[b+1] ^ (TAPS[b] & state[0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       state <= {{(W-1){1'b0}}, 1'b1};
      else if (load)    state <= (seed == '0) ? {{(W-1){1'b0}}, 1'b1} : seed;
      else if (adv)     state <= nxt;
   end

   AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0) else $error("lfsr reached zero"); // R9

   AST_LFSR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) && !$past(adv) |-> $stable(state)) else $error("lfsr moved without advance"); // R7
endmodule

// File: rtl/tpg_mask_table.sv
module tpg_mask_table #(
   parameter int unsigned W     = 32,
   parameter int unsigned NMASK = 14,
   parameter int unsigned IW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_addr,
   input  logic [W-1:0]  wr_care,
   input  logic [W-1:0]  wr_value,
   input  logic [IW-1:0] rd_addr,
   output logic [W-1:0]  rd_care,
   output logic [W-1:0]  rd_value
);
   logic [W-1:0] care_q  [NMASK];
   logic [W-1:0] value_q [NMASK];

   for (genvar e = 0; e < NMASK; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            care_q[e]  <= '0;
            value_q[e] <= '0;
         end else if (wr_en && wr_addr == IW'(e)) begin
            care_q[e]  <= wr_care;
            value_q[e] <= wr_value;
         end
      end
   end

   always_comb begin
      rd_care  = '0;
      rd_value = '0;
      for (int e = 0; e < NMASK; e++) begin
         if (rd_addr == IW'(e)) begin
            rd_care  = care_q[e];
            rd_value = value_q[e];
         end
      end
   end
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
   import tpg_pkg::*;
#(
   parameter int unsigned IW = 4,
   parameter int unsigned RW = 8,
   parameter int unsigned CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          cfg_mode,
   input  logic          cfg_hold,
   input  logic [IW:0]   cfg_nmask,
   input  logic [RW-1:0] cfg_run,
   input  logic [CW-1:0] cfg_total,
   output logic          load,
   output logic          adv,
   output logic          busy,
   output logic          done,
   output logic          mask_on,
   output logic [IW-1:0] mask_idx
);
   arr_mode_e     mode_q;
   logic          hold_q;
   logic [IW:0]   nmask_q;
   logic [RW-1:0] run_q;
   logic [CW-1:0] total_q;
   logic [1:0]    phase;
   logic [IW:0]   midx;
   logic [RW-1:0] rcnt;
   logic [CW-1:0] vcnt;
   logic          last;
   logic          run_end;
   logic          hold_next;
   logic          sel;

   assign load    = start && !busy;
   assign last    = (vcnt == total_q - CW'(1));
   assign run_end = (rcnt == run_q - RW'(1));

   always_comb begin
      if (mode_q == ARR_INTERLEAVE)
         sel = (nmask_q != '0) && (phase == 2'(ILV_PERIOD - 1));
      else
         sel = (run_q != '0) && (midx < nmask_q);
   end

   assign mask_on   = busy && sel;
   assign mask_idx  = mask_on ? midx[IW-1:0] : '0;
   assign hold_next = (mode_q == ARR_BLOCK) && hold_q && mask_on && run_end;
   assign adv       = busy && !last && !hold_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= ARR_INTERLEAVE;
         hold_q  <= 1'b0;
         nmask_q <= '0;
         run_q   <= '0;
         total_q <= '0;
         phase   <= '0;
         midx    <= '0;
         rcnt    <= '0;
         vcnt    <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else if (load) begin
         mode_q  <= arr_mode_e'(cfg_mode);
         hold_q  <= cfg_hold;
         nmask_q <= cfg_nmask;
         run_q   <= cfg_run;
         total_q <= cfg_total;
         phase   <= '0;
         midx    <= '0;
         rcnt    <= '0;
         vcnt    <= '0;
         busy    <= (cfg_total != '0);
         done    <= (cfg_total == '0);
      end else if (busy) begin
         vcnt <= vcnt + CW'(1);
         if (last) begin
            busy <= 1'b0;
            done <= 1'b1;
         end
         if (mode_q == ARR_INTERLEAVE) begin
            if (phase == 2'(ILV_PERIOD - 1)) begin
               phase <= '0;
               midx  <= (midx + (IW+1)'(1) >= nmask_q) ? '0 : midx + (IW+1)'(1);
            end else begin
               phase <= phase + 2'd1;
            end
         end else if (sel) begin
            if (run_end) begin
               rcnt <= '0;
               midx <= midx + (IW+1)'(1);
            end else begin
               rcnt <= rcnt + RW'(1);
            end
         end
      end
   end

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mask_on |-> midx < nmask_q) else $error("mask index beyond loaded count"); // R4

   AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done)) else $error("busy and done together"); // R7

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> vcnt == $past(vcnt) + CW'(1)) else $error("vector count skipped"); // R7

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> done) else $error("done dropped without start"); // R7

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !last |=> busy && vcnt != '0) else $error("start restarted a busy session"); // R12
endmodule

// File: rtl/masked_tpg.sv
module masked_tpg #(
   parameter int unsigned  W     = 32,
   parameter int unsigned  NMASK = 14,
   parameter int unsigned  RW    = 8,
   parameter int unsigned  CW    = 16,
   parameter logic [W-1:0] TAPS  = 32'h8020_0003,
   localparam int unsigned IW    = (NMASK > 1) ? $clog2(NMASK) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          cfg_mode,
   input  logic          cfg_hold,
   input  logic [IW:0]   cfg_nmask,
   input  logic [RW-1:0] cfg_run,
   input  logic [CW-1:0] cfg_total,
   input  logic [W-1:0]  cfg_seed,
   input  logic          mw_en,
   input  logic [IW-1:0] mw_addr,
   input  logic [W-1:0]  mw_care,
   input  logic [W-1:0]  mw_value,
   output logic [W-1:0]  vec_out,
   output logic          vec_valid,
   output logic          vec_masked,
   output logic [IW-1:0] mask_idx,
   output logic          done
);
   if (W < 2) begin : g_bad_width
      $error("W must be at least 2");
   end
   if (NMASK < 1) begin : g_bad_depth
      $error("NMASK must be at least 1");
   end
   if (TAPS[W-1] != 1'b1) begin : g_bad_taps
      $error("TAPS must include the top term");
   end

   logic          load;
   logic          adv;
   logic          busy;
   logic          mask_on;
   logic [IW-1:0] idx;
   logic [W-1:0]  lfsr;
   logic [W-1:0]  care;
   logic [W-1:0]  value;

   tpg_seq #(.IW(IW), .RW(RW), .CW(CW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_mode(cfg_mode), .cfg_hold(cfg_hold), .cfg_nmask(cfg_nmask),
      .cfg_run(cfg_run), .cfg_total(cfg_total),
      .load(load), .adv(adv), .busy(busy), .done(done),
      .mask_on(mask_on), .mask_idx(idx)
   );

   tpg_lfsr #(.W(W), .TAPS(TAPS)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .load(load), .seed(cfg_seed),
      .adv(adv), .state(lfsr)
   );

   tpg_mask_table #(.W(W), .NMASK(NMASK), .IW(IW)) u_tab (
      .clk(clk), .rst_n(rst_n), .wr_en(mw_en), .wr_addr(mw_addr),
      .wr_care(mw_care), .wr_value(mw_value),
      .rd_addr(idx), .rd_care(care), .rd_value(value)
   );

   assign vec_out    = mask_on ? ((lfsr & ~care) | (value & care)) : lfsr;
   assign vec_valid  = busy;
   assign vec_masked = mask_on;
   assign mask_idx   = idx;

   AST_CARE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      vec_masked |-> ((vec_out ^ value) & care) == '0) else $error("care bit not forced"); // R3

   AST_FREE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid && !vec_masked |-> vec_out == lfsr) else $error("raw vector altered"); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> !vec_masked && mask_idx == '0) else $error("mask shown while idle"); // R1
endmodule

// File: tb/masked_tpg_test.sv
`timescale 1ns/1ps
module masked_tpg_test;
   localparam int W = 32;
   localparam int NMASK = 14;
   localparam int IW = 4;
   localparam int RW = 8;
   localparam int CW = 16;
   localparam logic [W-1:0] POLY = 32'h8020_0003;

   // session table: mode, hold, nmask, run, total, seed
   localparam int NS = 7;
   localparam int S_MODE [NS] = '{0, 0, 1, 1, 1, 1, 1};
   localparam int S_HOLD [NS] = '{0, 0, 0, 1, 0, 1, 0};
   localparam int S_NM   [NS] = '{4, 14, 3, 3, 14, 2, 0};
   localparam int S_RUN  [NS] = '{1, 1, 5, 4, 2, 1, 3};
   localparam int S_TOT  [NS] = '{30, 60, 25, 20, 40, 6, 10};
   localparam int S_SEED [NS] = '{1, 32'h5EED_BEEF, 32'h0F0F_1234, 32'h1357_9BDF,
                                  32'h7000_0001, 32'h2468_ACE0, 0};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          cfg_mode = 1'b0;
   logic          cfg_hold = 1'b0;
   logic [IW:0]   cfg_nmask = '0;
   logic [RW-1:0] cfg_run = '0;
   logic [CW-1:0] cfg_total = '0;
   logic [W-1:0]  cfg_seed = '0;
   logic          mw_en = 1'b0;
   logic [IW-1:0] mw_addr = '0;
   logic [W-1:0]  mw_care = '0;
   logic [W-1:0]  mw_value = '0;
   logic [W-1:0]  vec_out;
   logic          vec_valid;
   logic          vec_masked;
   logic [IW-1:0] mask_idx;
   logic          done;

   logic [W-1:0] care_tab [NMASK];
   logic [W-1:0] val_tab  [NMASK];
   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   masked_tpg uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_mode(cfg_mode), .cfg_hold(cfg_hold), .cfg_nmask(cfg_nmask),
      .cfg_run(cfg_run), .cfg_total(cfg_total), .cfg_seed(cfg_seed),
      .mw_en(mw_en), .mw_addr(mw_addr), .mw_care(mw_care), .mw_value(mw_value),
      .vec_out(vec_out), .vec_valid(vec_valid), .vec_masked(vec_masked),
      .mask_idx(mask_idx), .done(done)
   );

   function automatic logic [W-1:0] step(input logic [W-1:0] s);
      return (s >> 1) ^ (s[0] ? POLY : '0);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic write_mask(input int i, input logic [W-1:0] c, input logic [W-1:0] v);
      @(negedge clk);
      mw_en = 1'b1; mw_addr = IW'(i); mw_care = c; mw_value = v;
      @(negedge clk);
      mw_en = 1'b0;
      care_tab[i] = c; val_tab[i] = v;
   endtask

   // starts a session and checks every vector; disturb exercises R8 and R12
   task automatic run_session(input int mode, input int hold, input int nm, input int run,
                              input int total, input int seed, input bit disturb);
      logic [W-1:0] ref_w;
      logic [W-1:0] exp_w;
      bit           m;
      int           ix;
      string        tag;
      @(negedge clk);
      cfg_mode = mode[0]; cfg_hold = hold[0]; cfg_nmask = (IW+1)'(nm);
      cfg_run = RW'(run); cfg_total = CW'(total); cfg_seed = W'(seed);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ref_w = '0;
      tag = (mode == 0) ? "R4" : ((hold != 0) ? "R6" : "R5");
      for (int k = 0; k < total; k++) begin
         if (k == 0) ref_w = (W'(seed) == '0) ? W'(1) : W'(seed);
         else if (!(mode == 1 && hold != 0 && run != 0 && k % run == 0 && k <= nm * run))
            ref_w = step(ref_w);
         if (mode == 0) begin
            m = (nm != 0) && (k % 3 == 2);
            ix = (nm != 0) ? (k / 3) % nm : 0;
         end else begin
            m = (run != 0) && (k < nm * run);
            ix = (run != 0) ? k / run : 0;
         end
         if (!m) ix = 0;
         exp_w = m ? ((ref_w & ~care_tab[ix]) | (val_tab[ix] & care_tab[ix])) : ref_w;
         chk(vec_valid === 1'b1, "R7", $sformatf("valid k=%0d", k), W'(vec_valid), 1);
         chk(vec_out === exp_w, m ? (disturb ? "R8" : "R3") : (disturb ? "R12" : "R2"),
             $sformatf("%s word k=%0d", tag, k), vec_out, exp_w);
         chk(vec_masked === m && mask_idx === IW'(ix), tag,
             $sformatf("mask sel k=%0d", k), {vec_masked, 27'd0, mask_idx},
             {m, 27'd0, IW'(ix)});
         if (disturb && k == 5) begin
            cfg_mode = ~mode[0]; cfg_seed = 32'h0000_1234; cfg_total = 3;
            cfg_nmask = 1; cfg_run = 9; start = 1'b1;
         end
         if (disturb && k == 6) start = 1'b0;
         @(negedge clk);
      end
      chk(done === 1'b1 && vec_valid === 1'b0, "R7", "done after last",
          {done, vec_valid}, 2'b10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] idle_w;
      repeat (3) @(negedge clk);
      chk(vec_valid === 1'b0 && vec_masked === 1'b0 && done === 1'b0 && mask_idx === '0,
          "R1", "reset outputs", {vec_valid, vec_masked, done, mask_idx}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(vec_valid === 1'b0 && done === 1'b0, "R1", "idle after reset",
          {vec_valid, done}, '0);

      for (int i = 0; i < NMASK; i++)
         write_mask(i, (32'h0000_0011 << i) | (32'h0100_0000 << (i % 7)),
                    32'hA5A5_A5A5 ^ {4{8'(i * 17)}});

      for (int s = 0; s < NS; s++)
         run_session(S_MODE[s], S_HOLD[s], S_NM[s], S_RUN[s], S_TOT[s], S_SEED[s], 1'b0);

      // R7: frozen and quiet while idle
      idle_w = vec_out;
      repeat (5) @(negedge clk);
      chk(vec_out === idle_w && vec_valid === 1'b0 && done === 1'b1, "R7", "idle freeze",
          vec_out, idle_w);

      // R8 / R12: start and config changes mid-session are ignored
      run_session(0, 0, 4, 1, 30, 32'h0BAD_F00D, 1'b1);
      run_session(1, 1, 2, 3, 12, 32'h0000_00F1, 1'b1);

      // R10: run-time rewrite of mask 0
      write_mask(0, 32'hFFFF_0000, 32'h1234_5678);
      run_session(0, 0, 1, 1, 9, 32'h4444_4444, 1'b0);
      write_mask(3, 32'h8000_0001, 32'h8000_0001);
      run_session(1, 0, 4, 2, 10, 32'h0000_9999, 1'b0);

      // R11: zero-length session
      @(negedge clk);
      cfg_total = '0; cfg_mode = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done === 1'b1 && vec_valid === 1'b0, "R11", "zero total", {done, vec_valid}, 2'b10);
      repeat (3) @(negedge clk);
      chk(done === 1'b1 && vec_valid === 1'b0, "R11", "zero total stays idle",
          {done, vec_valid}, 2'b10);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule